// File: doc/BRIEF.md
# Clock Output Stop and Enable Gating

This block sits between the clock synthesis stage of a system clock generator and its output drivers. It receives one free-running clock train per source (processor, peripheral bus, graphics port, memory, reference, 24 MHz and 48 MHz). It fans each train out to the outputs that source feeds. Each output either follows its train or is parked low. Two asynchronous active-low stop requests can silence groups of outputs. A per-output enable vector can silence single outputs. A global float bit releases every output enable at once.

The train inputs are oversampled waveforms in the domain of `clk`. Each stop request is resynchronised by a flop chain. The gate of an output may only change while that output's train is low, so a high pulse is always passed whole or blocked whole. The operating mode is sampled at configuration time and is changed only while reset is held. In desktop mode the two stop pins act as memory clock outputs 10 and 11 and the stop requests are ignored. In mobile mode those two memory outputs do not exist and the stop requests are honoured.

Top module: `clkgate_top`

## Requirements
- R1: While `rst` is high, every bit of `gclk` and `gclk_oe` is 0.
- R2: In mobile mode (`mode_desktop`=0), `cpu_stop_n`=0 holds processor outputs 0 to 3 (indices 0 to 3) and graphics outputs 0 and 1 (indices 11 and 12) at 0 within 10 cycles. The peripheral outputs keep running.
- R3: In mobile mode, `pci_stop_n`=0 holds peripheral outputs 0 to 5 (indices 4 to 9) at 0 within 10 cycles. The free-running peripheral output (index 10) and the processor outputs keep running.
- R4: In desktop mode (`mode_desktop`=1), neither stop input has any effect on any output.
- R5: Memory outputs (indices 13 to 24), reference outputs (25, 26), the 24 MHz output (27) and the 48 MHz output (28) keep running while either stop input is low.
- R6: `out_en[i]`=0 holds `gclk[i]` at 0 within 10 cycles. `out_en[i]`=1 lets it run. The index map is the same as for `gclk`.
- R7: `tri_all`=1 drives every bit of `gclk_oe` to 0 on the next cycle. After it is cleared, the enables return within 3 cycles.
- R8: Memory outputs 10 and 11 (indices 23 and 24) are held at 0 with `gclk_oe` 0 in mobile mode whatever their enable bit is. In desktop mode they obey their enable bit.
- R9: Every high interval seen on an output is exactly as long as the high interval of its train, even while stops toggle. No output shows a shortened high pulse.
- R10: A running output is its train delayed by one register stage. Every rising edge of an output, including the first after a stop is released, follows a rising edge of its train.
- R11: Each stop request passes through a `SYNC_STAGES`-deep synchroniser (default 2) before it reaches any gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock for all gating logic |
| rst | input | 1 | Synchronous active-high reset |
| mode_desktop | input | 1 | Configuration-time mode: 1 desktop, 0 mobile |
| cpu_stop_n | input | 1 | Asynchronous active-low processor/graphics stop |
| pci_stop_n | input | 1 | Asynchronous active-low peripheral stop |
| trains | input | 7 | Source trains: 0 cpu, 1 pci, 2 agp, 3 memory, 4 ref, 5 24 MHz, 6 48 MHz |
| out_en | input | 29 | Per-output enable, 1 = run |
| tri_all | input | 1 | 1 releases every output enable |
| gclk | output | 29 | Gated clock outputs |
| gclk_oe | output | 29 | Output-enable per gated clock |

## Verification
The gating is tried with stops asserted one at a time and together, in both modes. The mobile runs separate the processor/graphics group from the peripheral group and show that the free-running peripheral output and the memory, reference and fixed outputs are exempt. The desktop runs show that the same stop levels change nothing. Single enable bits are cleared among running neighbours, which shows that gating is per output and not per group. A stop that toggles at an odd phase against a slower train checks that every high pulse keeps its full width and that every rising edge after release lines up with the train.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    // source trains
    typedef enum logic [2:0] {
        SRC_CPU = 3'd0,
        SRC_PCI = 3'd1,
        SRC_AGP = 3'd2,
        SRC_SDR = 3'd3,
        SRC_REF = 3'd4,
        SRC_F24 = 3'd5,
        SRC_F48 = 3'd6
    } src_e;

    localparam int NUM_SRC = 7;

    typedef enum logic [1:0] {
        GRP_FREE = 2'd0,
        GRP_CPU  = 2'd1,
        GRP_PCI  = 2'd2
    } stop_grp_e;

    typedef struct packed {
        src_e      src;
        stop_grp_e grp;
        logic      shared;   // exists only in desktop mode
    } out_cfg_t;

    localparam int N_CPU = 4;
    localparam int N_PCI = 6;
    localparam int N_AGP = 2;
    localparam int N_SDR = 12;
    localparam int N_REF = 2;

    localparam int IDX_CPU0 = 0;
    localparam int IDX_PCI0 = IDX_CPU0 + N_CPU;
    localparam int IDX_PCIF = IDX_PCI0 + N_PCI;
    localparam int IDX_AGP0 = IDX_PCIF + 1;
    localparam int IDX_SDR0 = IDX_AGP0 + N_AGP;
    localparam int IDX_REF0 = IDX_SDR0 + N_SDR;
    localparam int IDX_F24  = IDX_REF0 + N_REF;
    localparam int IDX_F48  = IDX_F24 + 1;
    localparam int N_OUT    = IDX_F48 + 1;

    localparam int IDX_SD10 = IDX_SDR0 + 10;
    localparam int IDX_SD11 = IDX_SDR0 + 11;

    function automatic out_cfg_t cfg_of(input int idx);
        out_cfg_t c;
        c.shared = 1'b0;
        c.grp    = GRP_FREE;
        if (idx < IDX_PCI0) begin
            c.src = SRC_CPU;
            c.grp = GRP_CPU;
        end else if (idx < IDX_PCIF) begin
            c.src = SRC_PCI;
            c.grp = GRP_PCI;
        end else if (idx == IDX_PCIF) begin
            c.src = SRC_PCI;
        end else if (idx < IDX_SDR0) begin
            c.src = SRC_AGP;
            c.grp = GRP_CPU;
        end else if (idx < IDX_REF0) begin
            c.src    = SRC_SDR;
            c.shared = (idx == IDX_SD10) || (idx == IDX_SD11);
        end else if (idx < IDX_F24) begin
            c.src = SRC_REF;
        end else if (idx == IDX_F24) begin
            c.src = SRC_F24;
        end else begin
            c.src = SRC_F48;
        end
        return c;
    endfunction

endpackage

// File: rtl/clkgate_sync.sv
module clkgate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], async_n};
    end

    assign sync_n = chain_q[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk2
            // R11: a request seen at the output was low two edges earlier
            p_sync_depth_r11: assert property (@(posedge clk) disable iff (rst)
                $fell(sync_n) |-> !$past(async_n, 2));
        end
    endgenerate
endmodule

// File: rtl/clkgate_policy.sv
module clkgate_policy
    import clkgate_pkg::*;
(
    input  logic             mode_desktop,
    input  logic             cpu_stop_sync_n,
    input  logic             pci_stop_sync_n,
    input  logic [N_OUT-1:0] out_en,
    input  logic             tri_all,
    output logic [N_OUT-1:0] run_req,
    output logic [N_OUT-1:0] oe_req
);
    logic cpu_halt, pci_halt;

    always_comb begin
        cpu_halt = !mode_desktop && !cpu_stop_sync_n;
        pci_halt = !mode_desktop && !pci_stop_sync_n;
    end

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        localparam out_cfg_t CFG = cfg_of(i);
        logic halted, present;
        always_comb begin
            halted  = (CFG.grp == GRP_CPU && cpu_halt) ||
                      (CFG.grp == GRP_PCI && pci_halt);
            present = !CFG.shared || mode_desktop;
            run_req[i] = out_en[i] && present && !halted;
            oe_req[i]  = present && !tri_all;
        end
    end
endmodule

// File: rtl/clkgate_cell.sv
module clkgate_cell (
    input  logic clk,
    input  logic rst,
    input  logic train,
    input  logic run_req,
    input  logic oe_req,
    output logic clk_o,
    output logic oe_o
);
    logic gate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
            clk_o  <= 1'b0;
            oe_o   <= 1'b0;
        end else begin
            if (!train) gate_q <= run_req;   // only move in the low phase
            clk_o <= train && gate_q;
            oe_o  <= oe_req;
        end
    end

    // R9: gate never changes while the train is high
    p_gate_low_phase_r9: assert property (@(posedge clk) disable iff (rst)
        (gate_q != $past(gate_q)) |-> !$past(train));

    // R10: an output rise needs an open gate and a high train
    p_rise_aligned_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_o) |-> ($past(gate_q) && $past(train)));
endmodule

// File: rtl/clkgate_top.sv
module clkgate_top
    import clkgate_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_desktop,
    input  logic               cpu_stop_n,
    input  logic               pci_stop_n,
    input  logic [NUM_SRC-1:0] trains,
    input  logic [N_OUT-1:0]   out_en,
    input  logic               tri_all,
    output logic [N_OUT-1:0]   gclk,
    output logic [N_OUT-1:0]   gclk_oe
);
    logic             cpu_sync_n, pci_sync_n;
    logic [N_OUT-1:0] run_req, oe_req;

    clkgate_sync #(.STAGES(SYNC_STAGES)) u_cpu_sync (
        .clk(clk), .rst(rst), .async_n(cpu_stop_n), .sync_n(cpu_sync_n));

    clkgate_sync #(.STAGES(SYNC_STAGES)) u_pci_sync (
        .clk(clk), .rst(rst), .async_n(pci_stop_n), .sync_n(pci_sync_n));

    clkgate_policy u_policy (
        .mode_desktop    (mode_desktop),
        .cpu_stop_sync_n (cpu_sync_n),
        .pci_stop_sync_n (pci_sync_n),
        .out_en          (out_en),
        .tri_all         (tri_all),
        .run_req         (run_req),
        .oe_req          (oe_req));

    for (genvar i = 0; i < N_OUT; i++) begin : g_cell
        localparam out_cfg_t CFG = cfg_of(i);
        clkgate_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .train   (trains[CFG.src]),
            .run_req (run_req[i]),
            .oe_req  (oe_req[i]),
            .clk_o   (gclk[i]),
            .oe_o    (gclk_oe[i]));
    end

    // R7: float request releases every enable on the next cycle
    p_float_all_r7: assert property (@(posedge clk) disable iff (rst)
        tri_all |=> (gclk_oe == '0));

    // R8: shared memory outputs stay silent and undriven in mobile mode
    p_shared_mobile_r8: assert property (@(posedge clk) disable iff (rst)
        !mode_desktop |=> (!gclk[IDX_SD10] && !gclk[IDX_SD11] &&
                           !gclk_oe[IDX_SD10] && !gclk_oe[IDX_SD11]));

    // R1: reset leaves all outputs parked
    p_reset_park_r1: assert property (@(posedge clk)
        $past(rst) |-> (gclk == '0));
endmodule

// File: tb/test_clkgate_top.sv
module test_clkgate_top;
    localparam int NO = 29;
    localparam int NS = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_desktop = 1'b1;
    logic          cpu_stop_n = 1'b1;
    logic          pci_stop_n = 1'b1;
    logic [NS-1:0] trains = '0;
    logic [NO-1:0] out_en = '1;
    logic          tri_all = 1'b0;
    logic [NO-1:0] gclk;
    logic [NO-1:0] gclk_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0]    cnt = '0;
    logic [NS-1:0] prev_train = '0;

    clkgate_top i_clkgate_top (
        .clk(clk), .rst(rst), .mode_desktop(mode_desktop),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
        .trains(trains), .out_en(out_en), .tri_all(tri_all),
        .gclk(gclk), .gclk_oe(gclk_oe));

    always #5 clk = ~clk;

    function automatic logic [NS-1:0] make_trains(input logic [7:0] c);
        logic [NS-1:0] t;
        t[0] = c[0]; t[1] = c[1]; t[2] = c[0]; t[3] = c[0];
        t[4] = c[2]; t[5] = c[2]; t[6] = c[1];
        return t;
    endfunction

    // output index -> source, from the index map in the requirements
    function automatic int src_of(input int idx);
        if (idx < 4)  return 0;
        if (idx < 11) return 1;
        if (idx < 13) return 2;
        if (idx < 25) return 3;
        if (idx < 27) return 4;
        if (idx == 27) return 5;
        return 6;
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            prev_train = trains;
            #1;
            cnt    = cnt + 8'd1;
            trains = make_trains(cnt);
        end
    end

    task automatic fail(input string req, input string what, input int act, input int exp);
        errors++;
        $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic desk);
        rst = 1'b1; mode_desktop = desk; cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        out_en = '1; tri_all = 1'b0;
        settle(3);
        rst = 1'b0;
        settle(10);
    endtask

    // output must track its train delayed by one stage for 16 cycles
    task automatic check_run(input int idx, input string req);
        int bad = 0, act = 0, exp = 0;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (gclk[idx] !== prev_train[src_of(idx)] && bad == 0) begin
                bad = 1; act = gclk[idx]; exp = prev_train[src_of(idx)];
            end
        end
        checks++;
        if (bad != 0) fail(req, $sformatf("run idx %0d", idx), act, exp);
    endtask

    task automatic check_low(input int idx, input string req);
        int bad = 0;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (gclk[idx] !== 1'b0) bad = 1;
        end
        checks++;
        if (bad != 0) fail(req, $sformatf("low idx %0d", idx), 1, 0);
    endtask

    task automatic t_reset;
        rst = 1'b1; mode_desktop = 1'b1;
        settle(4);
        checks++;
        if (gclk !== '0)    fail("R1", "gclk in reset", int'(gclk), 0);
        checks++;
        if (gclk_oe !== '0) fail("R1", "oe in reset", int'(gclk_oe), 0);
    endtask

    task automatic t_cpu_stop;
        do_reset(1'b0);
        cpu_stop_n = 1'b0;
        settle(10);
        check_low(0, "R2"); check_low(3, "R2");
        check_low(11, "R2"); check_low(12, "R2");
        check_run(5, "R2");
        check_run(13, "R5"); check_run(25, "R5");
        cpu_stop_n = 1'b1;
        settle(10);
        check_run(0, "R10"); check_run(12, "R10");
    endtask

    task automatic t_pci_stop;
        do_reset(1'b0);
        pci_stop_n = 1'b0;
        settle(10);
        check_low(4, "R3"); check_low(9, "R3");
        check_run(10, "R3"); check_run(1, "R3");
        check_run(27, "R5"); check_run(28, "R5"); check_run(20, "R5");
        pci_stop_n = 1'b1;
        settle(10);
        check_run(7, "R10");
    endtask

    task automatic t_desktop;
        do_reset(1'b1);
        cpu_stop_n = 1'b0; pci_stop_n = 1'b0;
        settle(10);
        check_run(2, "R4"); check_run(6, "R4"); check_run(11, "R4");
        check_run(23, "R8"); check_run(24, "R8");
        checks++;
        if (gclk_oe !== '1) fail("R4", "oe desktop", int'(gclk_oe), int'({NO{1'b1}}));
        out_en[24] = 1'b0;
        settle(10);
        check_low(24, "R8");
    endtask

    task automatic t_enable;
        do_reset(1'b1);
        out_en[6] = 1'b0; out_en[18] = 1'b0;
        settle(10);
        check_low(6, "R6"); check_low(18, "R6");
        check_run(5, "R6"); check_run(17, "R6");
        out_en[6] = 1'b1; out_en[18] = 1'b1;
        settle(10);
        check_run(6, "R6"); check_run(18, "R6");
    endtask

    task automatic t_tristate;
        do_reset(1'b1);
        @(negedge clk); tri_all = 1'b1;
        settle(2);
        checks++;
        if (gclk_oe !== '0) fail("R7", "oe float", int'(gclk_oe), 0);
        tri_all = 1'b0;
        settle(3);
        checks++;
        if (gclk_oe !== '1) fail("R7", "oe restore", int'(gclk_oe), int'({NO{1'b1}}));
    endtask

    task automatic t_shared_mobile;
        do_reset(1'b0);
        out_en = '1;
        check_low(23, "R8"); check_low(24, "R8");
        checks++;
        if (gclk_oe[24:23] !== 2'b00) fail("R8", "oe shared", int'(gclk_oe[24:23]), 0);
        check_run(22, "R8");
    endtask

    // stop toggles every 5 cycles against a 2-high / 2-low train
    task automatic t_runt;
        int run = 0, bad9 = 0, bad10 = 0, bad_len = 0;
        do_reset(1'b0);
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (k % 5 == 0) pci_stop_n = ~pci_stop_n;
            if (gclk[4] === 1'b1) begin
                if (prev_train[1] !== 1'b1) bad10 = 1;
                run++;
            end else begin
                if (run != 0 && run != 2) begin bad9 = 1; bad_len = run; end
                run = 0;
            end
        end
        pci_stop_n = 1'b1;
        checks++;
        if (bad9 != 0)  fail("R9", "high width", bad_len, 2);
        checks++;
        if (bad10 != 0) fail("R10", "rise alignment", 1, 0);
    endtask

    // R11: a stop shorter than the sync delay still reaches the gate late, not early
    task automatic t_sync;
        do_reset(1'b0);
        @(negedge clk);
        cpu_stop_n = 1'b0;
        @(negedge clk);
        checks++;
        if (gclk[0] !== prev_train[0]) fail("R11", "early stop", gclk[0], prev_train[0]);
        settle(10);
        check_low(1, "R11");
        cpu_stop_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_cpu_stop();
        t_pci_stop();
        t_desktop();
        t_enable();
        t_tristate();
        t_shared_mobile();
        t_runt();
        t_sync();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule